// File: doc/BRIEF.md
# Register File with Operand Staging

This block holds the general-purpose registers of a small multi-cycle processor, together with three staging registers around them. Two read ports, addressed by the source fields of the instruction word, feed the operand latches A and B when their capture enables are raised. A third latch, C, takes a result from the internal result bus and holds it until a later cycle writes it back into the array. For a store, the B latch carries the value that goes out to memory.

Write-back always takes its data from the C latch, never straight from the bus. A small selector picks the destination index. The link select forces the topmost register, the I-type select chooses the I-type destination field, and otherwise the R-type destination field is used. The selector works as a three-way choice (RTYPE, ITYPE, LINK), with LINK taking priority over ITYPE. Register 0 is hard-wired to zero. The array is read combinationally, so a latch capture in the same cycle as a write sees the value from before the write.

Top module: `regfile_stage`

## Requirements
- R1: After an active-low reset, a_out and b_out are zero and every register in the array reads as zero.
- R2: When a_en is high at a rising clock edge, a_out takes the register addressed by rs1_idx. When a_en is low, a_out holds its value.
- R3: When b_en is high at a rising clock edge, b_out takes the register addressed by rs2_idx. When b_en is low, b_out holds its value.
- R4: When c_en is high at a rising clock edge, the C latch takes c_bus. When c_en is low, the C latch holds its value.
- R5: When wr_en is high and both itype_sel and link_sel are low, the C latch is written to the register addressed by rd_r_idx.
- R6: When wr_en and itype_sel are high and link_sel is low, the C latch is written to the register addressed by rd_i_idx.
- R7: When wr_en and link_sel are high, the C latch is written to register 31 (the highest index). Both destination fields and itype_sel are ignored.
- R8: Register 0 always reads as zero, and a write addressed to it has no effect.
- R9: When a write and an A or B capture happen in the same cycle, the latch takes the register value from before the write.
- R10: When wr_en is low, no register in the array changes.
- R11: When c_en and wr_en are both high in one cycle, the value written is the C latch content from before that edge, not c_bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| rd_r_idx | input | 5 | R-type destination index |
| rd_i_idx | input | 5 | I-type destination index |
| a_en | input | 1 | Capture enable for latch A |
| b_en | input | 1 | Capture enable for latch B |
| c_en | input | 1 | Capture enable for latch C |
| wr_en | input | 1 | Write C into the array |
| itype_sel | input | 1 | Use the I-type destination field |
| link_sel | input | 1 | Force the destination to register 31 |
| c_bus | input | 32 | Internal result bus into latch C |
| a_out | output | 32 | Latch A contents |
| b_out | output | 32 | Latch B contents |

## Verification
The bench builds the block with its default parameters: 32-bit data and 5-bit indices. With these values the forced link destination is the real register 31, and a full sweep of all 32 indices fits in a few dozen cycles. Because the array is small, the reference model can mirror every register and compare both operand latches on each clock. That comparison catches a wrong destination, a write to register 0, or a write that takes the bus value instead of the latch value, as soon as the corrupted register is read back. Directed cases cover same-cycle write and capture, and the priority of link over I-type. After those, a long stretch of arbitrary control patterns runs.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    typedef enum logic [1:0] {
        WB_RTYPE = 2'd0,
        WB_ITYPE = 2'd1,
        WB_LINK  = 2'd2
    } wb_src_e;
endpackage

// File: rtl/regfile_wb_sel.sv
module regfile_wb_sel
    import regfile_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] rd_r_idx,
    input  logic [ADDR_W-1:0] rd_i_idx,
    input  logic              itype_sel,
    input  logic              link_sel,
    output logic [ADDR_W-1:0] wb_idx
);
    localparam logic [ADDR_W-1:0] LINK_IDX = {ADDR_W{1'b1}};

    wb_src_e src;

    // Link has priority over the I-type select.
    always_comb begin
        if (link_sel)       src = WB_LINK;
        else if (itype_sel) src = WB_ITYPE;
        else                src = WB_RTYPE;
    end

    always_comb begin
        unique case (src)
            WB_LINK:  wb_idx = LINK_IDX;
            WB_ITYPE: wb_idx = rd_i_idx;
            WB_RTYPE: wb_idx = rd_r_idx;
            default:  wb_idx = rd_r_idx;
        endcase
    end
endmodule

// File: rtl/regfile_array.sv
module regfile_array #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd1_idx,
    input  logic [ADDR_W-1:0] rd2_idx,
    output logic [DATA_W-1:0] rd1_data,
    output logic [DATA_W-1:0] rd2_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NUM_REGS = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [NUM_REGS];

    // Index 0 is never written and never read from storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Combinational reads: a same-cycle capture sees the pre-write value.
    always_comb begin
        rd1_data = (rd1_idx == '0) ? '0 : mem[rd1_idx];
        rd2_data = (rd2_idx == '0) ? '0 : mem[rd2_idx];
    end

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_idx == '0) |-> (rd1_data == '0)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0)) |=> (mem[$past(wr_idx)] == $past(wr_data))); // R5
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (mem[$past(rd1_idx)] == $past(mem[rd1_idx]))); // R10
endmodule

// File: rtl/regfile_latches.sv
module regfile_latches #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              b_en,
    input  logic              c_en,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] c_in,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q,
    output logic [DATA_W-1:0] c_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
        end else begin
            if (a_en) a_q <= a_in;
            if (b_en) b_q <= b_in;
            if (c_en) c_q <= c_in;
        end
    end

    AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        a_en |=> (a_q == $past(a_in))); // R2
    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_q)); // R2
    AST_B_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        b_en |=> (b_q == $past(b_in))); // R3
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_q)); // R3
    AST_C_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        c_en |=> (c_q == $past(c_in))); // R4
    AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !c_en |=> $stable(c_q)); // R4
endmodule

// File: rtl/regfile_stage.sv
module regfile_stage #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rs1_idx,
    input  logic [ADDR_W-1:0] rs2_idx,
    input  logic [ADDR_W-1:0] rd_r_idx,
    input  logic [ADDR_W-1:0] rd_i_idx,
    input  logic              a_en,
    input  logic              b_en,
    input  logic              c_en,
    input  logic              wr_en,
    input  logic              itype_sel,
    input  logic              link_sel,
    input  logic [DATA_W-1:0] c_bus,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] b_out
);
    localparam logic [ADDR_W-1:0] LINK_IDX = {ADDR_W{1'b1}};

    logic [DATA_W-1:0] rd1_data;
    logic [DATA_W-1:0] rd2_data;
    logic [DATA_W-1:0] c_q;
    logic [ADDR_W-1:0] wb_idx;

    regfile_wb_sel #(.ADDR_W(ADDR_W)) u_sel (
        .rd_r_idx (rd_r_idx),
        .rd_i_idx (rd_i_idx),
        .itype_sel(itype_sel),
        .link_sel (link_sel),
        .wb_idx   (wb_idx)
    );

    regfile_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd1_idx (rs1_idx),
        .rd2_idx (rs2_idx),
        .rd1_data(rd1_data),
        .rd2_data(rd2_data),
        .wr_en   (wr_en),
        .wr_idx  (wb_idx),
        .wr_data (c_q)
    );

    regfile_latches #(.DATA_W(DATA_W)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .a_en (a_en),
        .b_en (b_en),
        .c_en (c_en),
        .a_in (rd1_data),
        .b_in (rd2_data),
        .c_in (c_bus),
        .a_q  (a_out),
        .b_q  (b_out),
        .c_q  (c_q)
    );

    AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        link_sel |-> (wb_idx == LINK_IDX)); // R7
    AST_ITYPE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (itype_sel && !link_sel) |-> (wb_idx == rd_i_idx)); // R6
    AST_RTYPE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!itype_sel && !link_sel) |-> (wb_idx == rd_r_idx)); // R5
endmodule

// File: tb/regfile_stage_test.sv
module regfile_stage_test;
    localparam int DW = 32;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] rs1_idx = '0, rs2_idx = '0, rd_r_idx = '0, rd_i_idx = '0;
    logic a_en = 0, b_en = 0, c_en = 0, wr_en = 0, itype_sel = 0, link_sel = 0;
    logic [DW-1:0] c_bus = '0;
    logic [DW-1:0] a_out, b_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state
    logic [DW-1:0] m_rf [32];
    logic [DW-1:0] m_a, m_b, m_c;

    always #2 clk = ~clk;

    regfile_stage #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .rd_r_idx(rd_r_idx), .rd_i_idx(rd_i_idx),
        .a_en(a_en), .b_en(b_en), .c_en(c_en), .wr_en(wr_en),
        .itype_sel(itype_sel), .link_sel(link_sel),
        .c_bus(c_bus), .a_out(a_out), .b_out(b_out)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [AW-1:0] r1, input logic [AW-1:0] r2,
                        input logic [AW-1:0] rdr, input logic [AW-1:0] rdi,
                        input logic ae, input logic be, input logic ce,
                        input logic we, input logic it, input logic lk,
                        input logic [DW-1:0] cb, input string tag);
        logic [DW-1:0] na, nb, nc;
        int dst;
        rs1_idx = r1; rs2_idx = r2; rd_r_idx = rdr; rd_i_idx = rdi;
        a_en = ae; b_en = be; c_en = ce; wr_en = we; itype_sel = it; link_sel = lk;
        c_bus = cb;
        @(posedge clk);
        na = ae ? m_rf[r1] : m_a;
        nb = be ? m_rf[r2] : m_b;
        nc = ce ? cb : m_c;
        if (we) begin
            dst = lk ? 31 : (it ? int'(rdi) : int'(rdr));
            if (dst != 0) m_rf[dst] = m_c;
        end
        m_a = na; m_b = nb; m_c = nc;
        @(negedge clk);
        check(tag, a_out, m_a, "a_out");
        check(tag, b_out, m_b, "b_out");
    endtask

    task automatic idle(input string tag);
        step('0, '0, '0, '0, 0, 0, 0, 0, 0, 0, '0, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_a = '0; m_b = '0; m_c = '0;
        repeat (3) @(negedge clk);
        check("R1", a_out, '0, "a_out in reset");
        check("R1", b_out, '0, "b_out in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: sweep every register through both ports
        for (int i = 0; i < 32; i++)
            step(AW'(i), AW'(31 - i), '0, '0, 1, 1, 0, 0, 0, 0, '0, "R1");

        // R4 then R5: stage a value and write it via the R-type field
        step('0, '0, '0, '0, 0, 0, 1, 0, 0, 0, 32'hA5A5_0001, "R4");
        step('0, '0, 5'd5, 5'd6, 0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, "R5");
        step(5'd5, 5'd6, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R5");
        // R2 hold: A does not move while its enable is low
        step(5'd0, 5'd5, '0, '0, 0, 1, 0, 0, 0, 0, '0, "R2");
        step(5'd5, 5'd0, '0, '0, 0, 0, 0, 0, 0, 0, '0, "R3");

        // R6: I-type destination
        step('0, '0, '0, '0, 0, 0, 1, 0, 0, 0, 32'h1234_5678, "R4");
        step('0, '0, 5'd9, 5'd7, 0, 0, 0, 1, 1, 0, '0, "R6");
        step(5'd7, 5'd9, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R6");

        // R7: link forces register 31 even with itype_sel high
        step('0, '0, '0, '0, 0, 0, 1, 0, 0, 0, 32'hCAFE_0031, "R4");
        step('0, '0, 5'd3, 5'd4, 0, 0, 0, 1, 1, 1, '0, "R7");
        step(5'd31, 5'd3, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R7");
        step(5'd4, 5'd4, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R7");

        // R8: writes to register 0 are dropped
        step('0, '0, '0, '0, 0, 0, 1, 0, 0, 0, 32'hDEAD_BEEF, "R4");
        step('0, '0, 5'd0, 5'd0, 0, 0, 0, 1, 0, 0, '0, "R8");
        step(5'd0, 5'd0, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R8");

        // R9: same-cycle write and capture sees the old value of register 5
        step('0, '0, '0, '0, 0, 0, 1, 0, 0, 0, 32'h0BAD_F00D, "R4");
        step(5'd5, 5'd5, 5'd5, '0, 1, 1, 0, 1, 0, 0, '0, "R9");
        step(5'd5, 5'd5, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R9");

        // R11: write in the same cycle as a C load uses the older C
        step('0, '0, 5'd10, '0, 0, 0, 1, 1, 0, 0, 32'h7777_7777, "R11");
        step(5'd10, 5'd10, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R11");

        // R10: no write enable, all other controls busy
        step('0, '0, 5'd12, 5'd13, 0, 0, 0, 0, 1, 1, 32'h5555_AAAA, "R10");
        step(5'd31, 5'd12, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R10");
        step(5'd13, 5'd13, '0, '0, 1, 1, 0, 0, 0, 0, '0, "R10");

        // Mixed patterns, checked against the model each clock
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(AW'(r[4:0]), AW'(r[9:5]), AW'(r[14:10]), AW'(r[19:15]),
                 r[20], r[21], r[22], r[23], r[24], r[25] & r[26], $urandom, "R5");
        end
        // Final sweep to expose any stray register contents
        for (int i = 0; i < 32; i++)
            step(AW'(i), AW'(i), '0, '0, 1, 1, 0, 0, 0, 0, '0, "R10");
        idle("R2");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule